// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire stereo PCM stream into two parallel sample words. It runs entirely on a master clock at 256 times the sample rate. The bit clock, the frame (LR) clock and the data line are treated as plain inputs that are synchronous to that master clock. Each is registered once and then edge-detected, so the block contains no second clock domain. One shift path handles I2S, MSB-justified and LSB-justified framing at a word length of 16 or 18 bits. A 3-bit format code selects among these.

Every LR-clock transition ends one channel's word. On that transition the captured bits are moved into the left or right output register. The choice of register depends on the framing and on the edge polarity. When the right word lands, a single-cycle valid strobe marks a complete stereo pair.

A frame monitor runs alongside the shift path. It times the spacing of rising LR edges in master clocks and raises a sync-lost flag when the frame length is wrong. It also raises the flag when LR stops toggling. A downstream attenuator can use the flag to silence its output. The flag clears again only after the frame length has been correct for a set number of frames.

Top module: `pcm_serial_rx`

## Requirements
- R1: During and right after reset, `left_word` and `right_word` are zero, and `word_valid` and `sync_lost` are low.
- R2: In I2S a rising LR edge loads `left_word` and a falling edge loads `right_word`. In both justified framings a rising edge loads `right_word` and a falling edge loads `left_word`. Outside its load cycle each word register holds its value.
- R3: `fmt_sel[1:0]` picks the framing: 00 is I2S, 01 is MSB-justified, 10 is LSB-justified, and 11 acts as I2S. `fmt_sel[2]` picks the word length: 0 for 16 bits, 1 for 18 bits. Data is taken on rising bit-clock edges, MSB first.
- R4: `word_valid` is a one-cycle pulse, high exactly in the cycle in which `right_word` takes a new value.
- R5: In I2S the word consists of bit-clock rising edges 2 to N+1 after the LR edge. In MSB-justified it consists of edges 1 to N. Later bits in the same half-frame are ignored.
- R6: In LSB-justified the word is the last N bits sampled before the closing LR edge. Any bits before them are ignored.
- R7: A 16-bit word is sign-extended to the 18-bit output. An 18-bit word is presented unchanged.
- R8: The frame length is the interval between consecutive rising LR edges, counted in master clocks. `sync_lost` is set when this length differs from 256 by more than 10. It is also set when no rising edge arrives within 267 clocks of the previous one. The first rising edge after reset has no interval to measure.
- R9: Once set, `sync_lost` clears only after two consecutive frames of valid length. A bad frame restarts that count.
- R10: Word registers, `word_valid` and `sync_lost` change on the second master-clock rising edge after the input change that causes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Serial bit clock, synchronous to clk |
| lrclk_in | input | 1 | Frame / channel-select clock, synchronous to clk |
| sdata_in | input | 1 | Serial audio data |
| fmt_sel | input | 3 | Format code (R3) |
| left_word | output | 18 | Last received left-channel sample |
| right_word | output | 18 | Last received right-channel sample |
| word_valid | output | 1 | Pulse when a new stereo pair is complete |
| sync_lost | output | 1 | High while frame timing is out of lock |

## Verification
Every result of this block appears two master-clock edges after the input transition that causes it. One edge is taken by the pin register and one by the output register. The bench drives on falling clock edges and samples each word, the valid strobe and the sync flag at the second falling edge after the LR transition. It also samples the valid strobe one falling edge earlier and one later, to confirm both the latency and the single-cycle width. Frame-length cases are laid out so that each rising LR edge that closes a padded or shortened frame coincides with the sampling point of the following frame.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  typedef enum logic [1:0] {
    FRM_I2S    = 2'b00,
    FRM_LEFTJ  = 2'b01,
    FRM_RIGHTJ = 2'b10,
    FRM_RSVD   = 2'b11
  } framing_e;

  // Reserved code falls back to I2S framing.
  function automatic framing_e decode_framing(input logic [2:0] code);
    case (code[1:0])
      2'b01:   return FRM_LEFTJ;
      2'b10:   return FRM_RIGHTJ;
      default: return FRM_I2S;
    endcase
  endfunction

  // Number of bit-clock edges skipped after the LR edge before data starts.
  function automatic int lead_gap(input framing_e f);
    return (f == FRM_I2S) ? 1 : 0;
  endfunction

  // Which LR edge closes the left word.
  function automatic logic left_on_rise(input framing_e f);
    return (f == FRM_I2S);
  endfunction

endpackage

// File: rtl/pcm_pin_sampler.sv
module pcm_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic lrclk_in,
  input  logic sdata_in,
  output logic bit_rise,
  output logic lr_rise,
  output logic lr_fall,
  output logic data_bit
);

  logic bclk_s1, lr_s1, data_s1;
  logic bclk_s2, lr_s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_s1 <= 1'b0;
      lr_s1   <= 1'b0;
      data_s1 <= 1'b0;
      bclk_s2 <= 1'b0;
      lr_s2   <= 1'b0;
    end else begin
      bclk_s1 <= bclk_in;
      lr_s1   <= lrclk_in;
      data_s1 <= sdata_in;
      bclk_s2 <= bclk_s1;
      lr_s2   <= lr_s1;
    end
  end

  assign bit_rise = bclk_s1 & ~bclk_s2;
  assign lr_rise  = lr_s1 & ~lr_s2;
  assign lr_fall  = ~lr_s1 & lr_s2;
  assign data_bit = data_s1;

endmodule

// File: rtl/pcm_word_shifter.sv
module pcm_word_shifter
  import pcm_rx_pkg::*;
#(
  parameter int MAXW   = 18,
  parameter int SHORTW = 16,
  parameter int SLOT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      fmt_code,
  input  logic            bit_rise,
  input  logic            data_bit,
  input  logic            lr_rise,
  input  logic            lr_fall,
  output logic [MAXW-1:0] left_word,
  output logic [MAXW-1:0] right_word,
  output logic            word_valid,
  output logic            left_load,
  output logic            right_load
);

  localparam int EXTW = MAXW - SHORTW;

  // Presents the captured bits as an output word; short words are sign-extended.
  function automatic logic [MAXW-1:0] widen(input logic [MAXW-1:0] v, input logic long_w);
    if (long_w) return v;
    return {{EXTW{v[SHORTW-1]}}, v[SHORTW-1:0]};
  endfunction

  framing_e          frm;
  logic              long_w;
  logic              lr_edge;
  logic              in_window;
  logic [MAXW-1:0]   shreg;
  logic [SLOT_W-1:0] slot;
  logic [MAXW-1:0]   word_now;
  int                first_idx;
  int                nbits;

  always_comb begin
    frm       = decode_framing(fmt_code);
    long_w    = fmt_code[2];
    nbits     = long_w ? MAXW : SHORTW;
    first_idx = lead_gap(frm);
    lr_edge   = lr_rise | lr_fall;
    if (frm == FRM_RIGHTJ)
      in_window = 1'b1;
    else
      in_window = (int'(slot) >= first_idx) && (int'(slot) < first_idx + nbits);
    left_load  = left_on_rise(frm) ? lr_rise : lr_fall;
    right_load = left_on_rise(frm) ? lr_fall : lr_rise;
    word_now   = widen(shreg, long_w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      slot  <= '0;
    end else if (lr_edge) begin
      shreg <= '0;
      slot  <= '0;
    end else if (bit_rise) begin
      if (in_window) shreg <= {shreg[MAXW-2:0], data_bit};
      if (slot != '1) slot <= slot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_word  <= '0;
      right_word <= '0;
      word_valid <= 1'b0;
    end else begin
      if (left_load)  left_word  <= word_now;
      if (right_load) right_word <= word_now;
      word_valid <= right_load;
    end
  end

endmodule

// File: rtl/pcm_frame_monitor.sv
module pcm_frame_monitor #(
  parameter int NOM_LEN     = 256,
  parameter int TOL         = 10,
  parameter int LOCK_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lr_rise,
  output logic sync_lost,
  output logic frame_good,
  output logic frame_bad,
  output logic lr_timeout
);

  localparam int SAT    = NOM_LEN + TOL + 1;
  localparam int CNT_W  = $clog2(SAT + 1);
  localparam int GOOD_W = $clog2(LOCK_FRAMES + 1);

  function automatic logic len_ok(input int span);
    return (span + TOL >= NOM_LEN) && (span <= NOM_LEN + TOL);
  endfunction

  logic [CNT_W-1:0]  cnt;
  logic [GOOD_W-1:0] good_cnt;
  logic              seen;
  int                span;

  always_comb begin
    span       = int'(cnt) + 1;
    frame_good = lr_rise && seen && len_ok(span);
    frame_bad  = lr_rise && seen && !len_ok(span);
    lr_timeout = seen && !lr_rise && (int'(cnt) == NOM_LEN + TOL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (lr_rise) begin
      cnt  <= '0;
      seen <= 1'b1;
    end else if (int'(cnt) != SAT) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_lost <= 1'b0;
      good_cnt  <= '0;
    end else if (frame_bad || lr_timeout) begin
      sync_lost <= 1'b1;
      good_cnt  <= '0;
    end else if (frame_good && sync_lost) begin
      if (int'(good_cnt) == LOCK_FRAMES - 1) begin
        sync_lost <= 1'b0;
        good_cnt  <= '0;
      end else begin
        good_cnt <= good_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx #(
  parameter int MAXW        = 18,
  parameter int SHORTW      = 16,
  parameter int NOM_LEN     = 256,
  parameter int TOL         = 10,
  parameter int LOCK_FRAMES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bclk_in,
  input  logic            lrclk_in,
  input  logic            sdata_in,
  input  logic [2:0]      fmt_sel,
  output logic [MAXW-1:0] left_word,
  output logic [MAXW-1:0] right_word,
  output logic            word_valid,
  output logic            sync_lost
);

  localparam int SLOT_W = $clog2(2 * MAXW + 4);

  logic bit_rise, lr_rise, lr_fall, data_bit;
  logic left_load, right_load;
  logic frame_good, frame_bad, lr_timeout;

  pcm_pin_sampler u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk_in  (bclk_in),
    .lrclk_in (lrclk_in),
    .sdata_in (sdata_in),
    .bit_rise (bit_rise),
    .lr_rise  (lr_rise),
    .lr_fall  (lr_fall),
    .data_bit (data_bit)
  );

  pcm_word_shifter #(
    .MAXW   (MAXW),
    .SHORTW (SHORTW),
    .SLOT_W (SLOT_W)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_code   (fmt_sel),
    .bit_rise   (bit_rise),
    .data_bit   (data_bit),
    .lr_rise    (lr_rise),
    .lr_fall    (lr_fall),
    .left_word  (left_word),
    .right_word (right_word),
    .word_valid (word_valid),
    .left_load  (left_load),
    .right_load (right_load)
  );

  pcm_frame_monitor #(
    .NOM_LEN     (NOM_LEN),
    .TOL         (TOL),
    .LOCK_FRAMES (LOCK_FRAMES)
  ) u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .lr_rise    (lr_rise),
    .sync_lost  (sync_lost),
    .frame_good (frame_good),
    .frame_bad  (frame_bad),
    .lr_timeout (lr_timeout)
  );

endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk #(
  parameter int MAXW = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            left_load,
  input logic            right_load,
  input logic            word_valid,
  input logic [MAXW-1:0] left_word,
  input logic [MAXW-1:0] right_word,
  input logic            sync_lost,
  input logic            frame_good,
  input logic            frame_bad
);

  AST_VALID_AFTER_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    right_load |=> word_valid);                                          // R4

  AST_VALID_NEEDS_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(right_load));                                   // R4

  AST_RIGHT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !right_load |=> $stable(right_word));                                // R2

  AST_LEFT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !left_load |=> $stable(left_word));                                  // R2

  AST_BAD_FRAME_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> sync_lost);                                            // R8

  AST_RELOCK_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_lost) |-> $past(frame_good));                             // R9

endmodule

bind pcm_serial_rx pcm_serial_rx_chk #(.MAXW(MAXW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .left_load  (left_load),
  .right_load (right_load),
  .word_valid (word_valid),
  .left_word  (left_word),
  .right_word (right_word),
  .sync_lost  (sync_lost),
  .frame_good (frame_good),
  .frame_bad  (frame_bad)
);

// File: tb/sim_pcm_serial_rx.sv
module sim_pcm_serial_rx;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0;
  logic        lrclk = 1'b0;
  logic        sdata = 1'b0;
  logic [2:0]  fmt = 3'b000;
  logic [17:0] left_word, right_word;
  logic        word_valid, sync_lost;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bit          pend = 0;
  bit          fresh = 1;
  logic [17:0] exp_r = '0;

  always #2.5 clk = ~clk;

  pcm_serial_rx u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_in    (bclk),
    .lrclk_in   (lrclk),
    .sdata_in   (sdata),
    .fmt_sel    (fmt),
    .left_word  (left_word),
    .right_word (right_word),
    .word_valid (word_valid),
    .sync_lost  (sync_lost)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  // R7: expected output word computed through signed integer arithmetic
  function automatic logic [17:0] exp_word(input logic [2:0] code, input logic [17:0] w);
    int v;
    if (code[2]) return w;
    v = int'(w[15:0]);
    if (v >= 32768) v = v - 65536;
    return v[17:0];
  endfunction

  // R3 R5 R6: serial bit for a given slot of a 32-slot half frame
  function automatic logic slot_bit(input logic [2:0] code, input int slot, input logic [17:0] w, input logic junk);
    int n;
    n = code[2] ? 18 : 16;
    case (code[1:0])
      2'b01:   return (slot < n) ? w[n-1-slot] : junk;
      2'b10:   return (slot >= 32 - n) ? w[31-slot] : junk;
      default: return (slot >= 1 && slot <= n) ? w[n-slot] : junk;
    endcase
  endfunction

  task automatic set_format(input logic [2:0] code);
    @(negedge clk);
    fmt   = code;
    pend  = 0;
    fresh = 1;
  endtask

  // One frame: left half then right half; checks for the previous frame's
  // right word (and sync state) at the frame-start edge, left word mid-frame.
  task automatic run_frame(input logic [17:0] wl, input logic [17:0] wr, input int pad, input int chk_sync);
    bit   is_i2s;
    logic lvl0;
    is_i2s = (fmt[1:0] != 2'b01) && (fmt[1:0] != 2'b10);
    lvl0   = is_i2s ? 1'b0 : 1'b1;
    for (int h = 0; h < 2; h++) begin
      logic [17:0] w;
      int          ncyc;
      w    = (h == 0) ? wl : wr;
      ncyc = 128 + ((h == 1) ? pad : 0);
      for (int c = 0; c < ncyc; c++) begin
        @(negedge clk);
        if (h == 0 && pend && c == 1)
          check(word_valid == 1'b0, "R10 valid early", {31'd0, word_valid}, 32'd0);
        if (h == 0 && pend && c == 2) begin
          check(word_valid == 1'b1, "R4 valid pulse", {31'd0, word_valid}, 32'd1);
          check(right_word == exp_r, "R2 R5 R6 right word", {14'd0, right_word}, {14'd0, exp_r});
        end
        if (h == 0 && pend && c == 3)
          check(word_valid == 1'b0, "R4 valid width", {31'd0, word_valid}, 32'd0);
        if (h == 0 && c == 2 && chk_sync >= 0)
          check(sync_lost == chk_sync[0], "R8 R9 sync flag", {31'd0, sync_lost}, chk_sync);
        if (h == 1 && !fresh && c == 2) begin
          check(left_word == exp_word(fmt, wl), "R2 R3 R7 left word", {14'd0, left_word}, {14'd0, exp_word(fmt, wl)});
          check(word_valid == 1'b0, "R4 no valid on left", {31'd0, word_valid}, 32'd0);
        end
        if (c < 128) begin
          bclk = ((c % 4) >= 2);
          if ((c % 4) == 0) begin
            lrclk = (h == 0) ? lvl0 : ~lvl0;
            sdata = slot_bit(fmt, c / 4, w, 1'($urandom));
          end
        end else begin
          bclk = 1'b0;
        end
      end
    end
    pend  = 1;
    fresh = 0;
    exp_r = exp_word(fmt, wr);
  endtask

  initial begin
    int seed_sink;
    logic [2:0] codes [6];
    codes = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b110};
    seed_sink = $urandom(32'h5EED);
    repeat (4) @(negedge clk);
    // R1: outputs under reset and just after release
    check(left_word == '0 && right_word == '0, "R1 words in reset", {14'd0, left_word}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(word_valid == 1'b0, "R1 valid after reset", {31'd0, word_valid}, 32'd0);
    check(sync_lost == 1'b0, "R1 sync after reset", {31'd0, sync_lost}, 32'd0);
    check(right_word == '0, "R1 right after reset", {14'd0, right_word}, 32'd0);

    // R3 R5 R6 R7: every format, directed extremes then random words
    foreach (codes[k]) begin
      set_format(codes[k]);
      run_frame(18'h0, 18'h0, 0, -1);
      run_frame(18'h2_0001, 18'h1_FFFE, 0, -1);
      run_frame(18'h0_8000, 18'h0_7FFF, 0, -1);
      run_frame(18'h3_FFFF, 18'h0_0001, 0, -1);
      for (int i = 0; i < 4; i++)
        run_frame(18'($urandom), 18'($urandom), 0, -1);
    end

    // R8 R9: frame length tolerance and relock, MSB-justified 16-bit
    set_format(3'b001);
    for (int i = 0; i < 4; i++) run_frame(18'($urandom), 18'($urandom), 0, -1);
    run_frame(18'h1234, 18'h5678, 10, 0);   // locked before
    run_frame(18'h1111, 18'h2222, -10, 0);  // R8 266 tolerated
    run_frame(18'h3333, 18'h4444, 11, 0);   // R8 246 tolerated
    run_frame(18'h5555, 18'h6666, 0, 1);    // R8 267 rejected
    run_frame(18'h7777, 18'h0888, 0, 1);    // R9 one good frame only
    run_frame(18'h0999, 18'h0AAA, -11, 0);  // R9 relocked after two
    run_frame(18'h0BBB, 18'h0CCC, 0, 1);    // R8 245 rejected
    run_frame(18'h0DDD, 18'h0EEE, 0, 1);
    run_frame(18'h0F0F, 18'h0F0F, 0, 0);
    // R8: LR stalls
    repeat (300) @(negedge clk);
    check(sync_lost == 1'b1, "R8 LR stall", {31'd0, sync_lost}, 32'd1);
    run_frame(18'h0101, 18'h0202, 0, 1);
    run_frame(18'h0303, 18'h0404, 0, 1);
    run_frame(18'h0505, 18'h0606, 0, 0);
    run_frame(18'h0707, 18'h0808, 0, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule